// File: doc/BRIEF.md
# Pulse-Swallow Programmable Clock Divider

This block divides its input clock by a programmable integer. It is a fully synchronous model of the classic three-part feedback divider: a dual-modulus prescaler, a swallow counter and a main counter. The prescaler counts input cycles and divides by either N or N−1. The swallow counter and the main counter each count prescaler periods. At the start of every output period the swallow counter holds the prescaler in its lower modulus, N−1. Once S prescaler periods have passed, the swallow counter releases it to divide by N. The main counter closes the output period after P prescaler periods. One output period therefore lasts S·(N−1) + (P−S)·N = P·N − S input cycles.

A one-cycle pulse marks each output period. The three settings are read only at a period boundary, so the running ratio never changes partway through a period. The main count must exceed the swallow count, and N must be at least 2. When a setting breaks either rule, the block raises an error flag and keeps its output quiet. It checks the settings again every cycle until they are legal, then restarts at once.

Top module: `psd_divider`

## Requirements
- R1: With legal settings, successive rising edges of `div_pulse` are exactly `main_p`·`base_n` − `swal_s` input clock cycles apart.
- R2: A swallow count of zero yields a period of `main_p`·`base_n` cycles (pure divide-by-N operation), and `base_n` = 2 with a nonzero swallow count runs the prescaler at divide-by-1 without losing cycles.
- R3: `div_pulse` is high for exactly one input clock cycle per output period.
- R4: If `main_p` ≤ `swal_s` is applied, `cfg_err` is 1 and `div_pulse` stays 0 for as long as that setting is held.
- R5: If `base_n` < 2 is applied, `cfg_err` is 1 and `div_pulse` stays 0 for as long as that setting is held.
- R6: A change of settings during a running period takes effect only at the end of that period. The period in progress completes with the old ratio, and an illegal setting raises `cfg_err` on the same edge as that period's final pulse.
- R7: While `cfg_err` is 1, applying legal settings clears `cfg_err` at the next clock edge. The first pulse then rises `main_p`·`base_n` − `swal_s` edges after that edge.
- R8: `rst` is synchronous and active high. While it is held, `div_pulse` and `cfg_err` are 0 whatever the settings. After release the block restarts in the same way as R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| base_n | input | NW | Prescaler base modulus N |
| main_p | input | PW | Main counter load P (prescaler periods per output period) |
| swal_s | input | SW | Swallow counter load S (prescaler periods at N−1) |
| div_pulse | output | 1 | One-cycle pulse, one per output period |
| cfg_err | output | 1 | Latched setting is illegal (P ≤ S or N < 2) |

## Verification
The bench goes after the ends of the legal range. These are S = P−1 with N = 2, where the prescaler divides by one; S = 0; P = 1; and the largest ratio in the table. If the design reloaded the prescaler with the wrong modulus at the swallow boundary, these periods would come out one or more cycles off. It changes settings partway through a period. A design that applied them early would give a short or long transitional period, or would flag an illegal setting before the old period ended. It also measures the latency from error recovery and from reset release to the first pulse. A design that wasted a cycle restarting, or that let the error state leak a pulse, would show the wrong gap.

// File: rtl/psd_pkg.sv
package psd_pkg;
  // Default widths of the three settings.
  localparam int unsigned DEF_NW = 4;
  localparam int unsigned DEF_PW = 8;
  localparam int unsigned DEF_SW = 6;

  // Prescaler modulus selection.
  typedef enum logic {
    MOD_FULL  = 1'b0,  // divide by N
    MOD_SHORT = 1'b1   // divide by N-1
  } psd_mod_e;
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int unsigned NW = DEF_NW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [NW-1:0] load_n,
  input  psd_mod_e      load_mod,
  input  logic          run,
  input  psd_mod_e      next_mod,
  output logic          tick
);
  localparam logic [NW-1:0] ONE = NW'(1);

  logic [NW-1:0] n_q;
  logic [NW-1:0] cnt_q;
  logic [NW-1:0] next_len;

  always_comb begin
    next_len = (next_mod == MOD_SHORT) ? (n_q - ONE) : n_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q   <= '0;
      cnt_q <= '0;
    end else if (load) begin
      n_q   <= load_n;
      cnt_q <= (load_mod == MOD_SHORT) ? (load_n - ONE) : load_n;
    end else if (run) begin
      if (cnt_q == ONE) cnt_q <= next_len;
      else              cnt_q <= cnt_q - ONE;
    end
  end

  assign tick = run && (cnt_q == ONE);

  // R1: a running prescaler never holds a zero count
  a_r1_pre_nonzero: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q != '0));
endmodule

// File: rtl/psd_swallow.sv
module psd_swallow
  import psd_pkg::*;
#(
  parameter int unsigned SW = DEF_SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [SW-1:0] load_s,
  input  logic          run,
  input  logic          tick,
  output psd_mod_e      mod,
  output psd_mod_e      next_mod
);
  localparam logic [SW-1:0] ONE = SW'(1);

  logic [SW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= load_s;
    end else if (run && tick && (left_q != '0)) begin
      left_q <= left_q - ONE;
    end
  end

  assign mod      = (left_q != '0) ? MOD_SHORT : MOD_FULL;
  assign next_mod = (left_q > ONE) ? MOD_SHORT : MOD_FULL;

  // R2: the short modulus is released only by a prescaler period or a reload
  a_r2_release_on_tick: assert property (@(posedge clk) disable iff (rst)
    (mod == MOD_FULL) && ($past(mod) == MOD_SHORT) |-> $past(tick || load));
endmodule

// File: rtl/psd_main.sv
module psd_main
  import psd_pkg::*;
#(
  parameter int unsigned PW = DEF_PW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] load_p,
  input  logic          run,
  input  logic          tick,
  output logic          last
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= load_p;
    end else if (run && tick) begin
      left_q <= left_q - ONE;
    end
  end

  assign last = run && tick && (left_q == ONE);

  // R1: while running the main count stays above zero
  a_r1_main_nonzero: assert property (@(posedge clk) disable iff (rst)
    run |-> (left_q != '0));
endmodule

// File: rtl/psd_divider.sv
module psd_divider
  import psd_pkg::*;
#(
  parameter int unsigned NW = DEF_NW,
  parameter int unsigned PW = DEF_PW,
  parameter int unsigned SW = DEF_SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] base_n,
  input  logic [PW-1:0] main_p,
  input  logic [SW-1:0] swal_s,
  output logic          div_pulse,
  output logic          cfg_err
);
  localparam logic [NW-1:0] MIN_N = NW'(2);

  logic     run_q;
  logic     err_q;
  logic     pulse_q;
  logic     legal;
  logic     reload;
  logic     tick;
  logic     period_end;
  psd_mod_e mod;
  psd_mod_e next_mod;
  psd_mod_e load_mod;

  always_comb begin
    legal    = (base_n >= MIN_N) && (int'(main_p) > int'(swal_s));
    load_mod = (swal_s != '0) ? MOD_SHORT : MOD_FULL;
    reload   = !run_q || period_end;
  end

  psd_prescaler #(.NW(NW)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .load     (reload),
    .load_n   (base_n),
    .load_mod (load_mod),
    .run      (run_q),
    .next_mod (next_mod),
    .tick     (tick)
  );

  psd_swallow #(.SW(SW)) u_swl (
    .clk      (clk),
    .rst      (rst),
    .load     (reload),
    .load_s   (swal_s),
    .run      (run_q),
    .tick     (tick),
    .mod      (mod),
    .next_mod (next_mod)
  );

  psd_main #(.PW(PW)) u_main (
    .clk    (clk),
    .rst    (rst),
    .load   (reload),
    .load_p (main_p),
    .run    (run_q),
    .tick   (tick),
    .last   (period_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      err_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= period_end;
      if (reload) begin
        run_q <= legal;
        err_q <= !legal;
      end
    end
  end

  assign div_pulse = pulse_q;
  assign cfg_err   = err_q;

  // R3: the output pulse never lasts two cycles
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R4, R5: a held error state emits no pulse
  a_r4_quiet_on_err: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && $past(cfg_err)) |-> !div_pulse);

  // R1: a period closes only after all swallowed prescaler periods are used
  a_r1_end_unswallowed: assert property (@(posedge clk) disable iff (rst)
    period_end |-> (mod == MOD_FULL));

  // R6: the error flag can rise only at a period boundary or while idle
  a_r6_err_at_boundary: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && !$past(cfg_err)) |-> $past(!run_q || period_end));
endmodule

// File: tb/test_psd_divider.sv
module test_psd_divider;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] base_n = '0;
  logic [7:0] main_p = '0;
  logic [5:0] swal_s = '0;
  logic       div_pulse;
  logic       cfg_err;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int last_at = 0;
  int last_gap = 0;
  int pulses = 0;
  int wide = 0;
  logic prev_pulse = 1'b0;
  logic err_at_pulse = 1'b0;
  bit done = 1'b0;

  // {N, P, S, expected period}
  localparam int NV = 9;
  localparam int VEC [NV][4] = '{
    '{2, 3, 0, 6},
    '{2, 3, 2, 4},
    '{4, 5, 1, 19},
    '{5, 7, 3, 32},
    '{8, 4, 3, 29},
    '{3, 10, 9, 21},
    '{15, 9, 4, 131},
    '{6, 1, 0, 6},
    '{2, 1, 0, 2}
  };

  psd_divider i_psd_divider (
    .clk       (clk),
    .rst       (rst),
    .base_n    (base_n),
    .main_p    (main_p),
    .swal_s    (swal_s),
    .div_pulse (div_pulse),
    .cfg_err   (cfg_err)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (div_pulse) begin
      last_gap     = cyc - last_at;
      last_at      = cyc;
      err_at_pulse = cfg_err;
      pulses++;
      if (prev_pulse) wide++;
    end
    prev_pulse = div_pulse;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int n, input int p, input int s);
    base_n = 4'(n);
    main_p = 8'(p);
    swal_s = 6'(s);
  endtask

  task automatic wait_pulse();
    int start = pulses;
    while (pulses == start) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    int p0;
    bit quiet;
    @(negedge clk);
    // R8: reset holds outputs low even with an illegal setting
    set_cfg(1, 3, 0);
    quiet = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (div_pulse || cfg_err) quiet = 1'b0;
    end
    chk(quiet, "R8 reset quiet", int'(quiet), 1);

    // R5: N below 2 after reset release
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_err == 1'b1, "R5 err for N=1", int'(cfg_err), 1);
    p0 = pulses;
    idle(40);
    chk(pulses == p0, "R5 no pulse for N=1", pulses - p0, 0);
    set_cfg(0, 5, 1);
    idle(2);
    chk(cfg_err == 1'b1, "R5 err for N=0", int'(cfg_err), 1);

    // R4: P equal to S, then P below S
    set_cfg(3, 2, 2);
    idle(2);
    chk(cfg_err == 1'b1, "R4 err for P=S", int'(cfg_err), 1);
    set_cfg(2, 3, 4);
    p0 = pulses;
    idle(40);
    chk(cfg_err == 1'b1 && pulses == p0, "R4 err and quiet for P<S", pulses - p0, 0);

    // R7: recovery from error state
    set_cfg(4, 5, 1);
    c0 = cyc;
    @(negedge clk);
    chk(cfg_err == 1'b0, "R7 err clears", int'(cfg_err), 0);
    wait_pulse();
    chk(last_at - c0 == 20, "R7 first pulse latency", last_at - c0, 20);

    // R1 / R2: table of settings
    for (int i = 0; i < NV; i++) begin
      set_cfg(VEC[i][0], VEC[i][1], VEC[i][2]);
      wait_pulse();
      wait_pulse();
      if (VEC[i][2] == 0 || VEC[i][0] == 2)
        chk(last_gap == VEC[i][3], "R2 boundary period", last_gap, VEC[i][3]);
      else
        chk(last_gap == VEC[i][3], "R1 period", last_gap, VEC[i][3]);
      chk(cfg_err == 1'b0, "R1 no error on legal setting", int'(cfg_err), 0);
    end

    // R6: legal change mid period
    set_cfg(4, 5, 1);
    wait_pulse();
    wait_pulse();
    idle(5);
    set_cfg(2, 3, 0);
    wait_pulse();
    chk(last_gap == 19, "R6 old ratio completes", last_gap, 19);
    wait_pulse();
    chk(last_gap == 6, "R6 new ratio next period", last_gap, 6);

    // R6: illegal change mid period
    set_cfg(15, 9, 4);
    wait_pulse();
    wait_pulse();
    idle(3);
    set_cfg(7, 4, 4);
    idle(10);
    chk(cfg_err == 1'b0, "R6 err deferred", int'(cfg_err), 0);
    wait_pulse();
    chk(last_gap == 131, "R6 period before error", last_gap, 131);
    chk(err_at_pulse == 1'b1, "R6 err with final pulse", int'(err_at_pulse), 1);
    p0 = pulses;
    idle(100);
    chk(cfg_err == 1'b1 && pulses == p0, "R4 held error quiet", pulses - p0, 0);

    // R8: reset while running, then restart latency
    set_cfg(3, 4, 2);
    wait_pulse();
    idle(3);
    rst = 1'b1;
    quiet = 1'b1;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (k > 0 && (div_pulse || cfg_err)) quiet = 1'b0;
    end
    chk(quiet, "R8 reset mid run quiet", int'(quiet), 1);
    rst = 1'b0;
    c0 = cyc;
    wait_pulse();
    chk(last_at - c0 == 11, "R8 restart latency", last_at - c0, 11);

    // R3: every pulse was one cycle wide
    chk(wide == 0, "R3 pulse width", wide, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule